// File: doc/BRIEF.md
# Multi-Lane Banked Scratchpad with Conflict Serialization

The block is a word-addressed scratchpad split into 16 independent banks of 32-bit words. A group of 16 lanes presents one request at a time. Each lane carries an enable, a word address, a direction flag and write data. The low address bits pick the bank and the remaining bits pick the row inside that bank. Each bank performs one row access per cycle. Lanes that reach distinct banks finish together in one cycle. Lanes that ask for the very same word share a single bank access. Lanes that need different rows of the same bank are spread over successive cycles.

A request is accepted when `req_valid` is high while the block is idle. From the next cycle `busy` stays high for as many cycles as the most heavily loaded bank needs, and the requesting group must hold off while it is high. `done` then pulses for one cycle and the per-lane read results appear together on `rdata`. They stay there until the next request is accepted. Inside a bank, pending rows are taken in the order of the lowest lane still waiting.

Top module: `lane_bank_scratch`

## Requirements
- R1: The bank is the word address modulo 16 (address bits [3:0]) and the row is address bits [7:4]. A word written at any address is returned by a later read of that address.
- R2: A request whose active lanes all use different banks keeps `busy` high for exactly one cycle.
- R3: Active reading lanes that carry the same address are served by one bank access, so they add no cycles and all receive the same word.
- R4: The number of `busy` cycles equals the largest count of distinct active addresses that fall in any one bank. Word strides of 1 and 3 across the lanes take 1 cycle, stride 2 takes 2, stride 8 takes 8 and stride 16 takes 16. The count is never more than the number of lanes.
- R5: When several active lanes write the same address in one request, the highest-numbered of them sets the stored value.
- R6: When one request both reads and writes the same address, the reading lanes get the value stored before the request.
- R7: `busy` rises in the cycle after acceptance. `done` is high for exactly one cycle, in the first cycle with `busy` low again. `rdata` does not change while the block is idle and no new request is being accepted.
- R8: A `req_valid` pulse that arrives while `busy` is high is ignored and writes nothing.
- R9: Inactive lanes write nothing. Inactive lanes and writing lanes return zero on `rdata`. A request with no active lane still takes one `busy` cycle.
- R10: After reset, `busy` and `done` are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Offers a request; taken only when idle |
| lane_act | input | 16 | Per-lane enable |
| lane_we | input | 16 | Per-lane direction, 1 = write |
| lane_addr | input | 128 | Per-lane word address, lane n in bits [8n+7:8n] |
| lane_wdata | input | 512 | Per-lane write data, lane n in bits [32n+31:32n] |
| busy | output | 1 | Stall: the request is still being served |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 512 | Per-lane read data, lane n in bits [32n+31:32n] |

## Verification
A request offered at one clock edge is captured at that edge. `busy` is seen high at each of the next K falling-edge sample points, where K is the bank load the bench derives from its own address list. At the first sample point with `busy` low, `done` and the full `rdata` word are due. The bench drives and samples only on falling edges and counts sample points rather than time. It compares that count with K and checks `done` and every lane's data at that sample point. A further sample point confirms that the pulse has ended and that the data has not moved.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;

  // Controller phase: waiting for a request, or walking the bank queues.
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SERVE = 1'b1
  } ctl_state_e;

endpackage

// File: rtl/lbs_bank_pick.sv
`timescale 1ns/1ps
// Per-bank selector: among lanes still pending on this bank, take the row of
// the lowest such lane and serve every pending lane that targets that row.
module lbs_bank_pick #(
  parameter int LANES   = 16,
  parameter int BANKS   = 16,
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 32,
  parameter int BANK_ID = 0,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic [LANES-1:0]        pend_i,
  input  logic [LANES*ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [LANES*WORD_W-1:0] wdata_i,
  output logic [LANES-1:0]        serve_o,
  output logic                    wr_o,
  output logic [ROW_W-1:0]        row_o,
  output logic [WORD_W-1:0]       wdata_o
);

  logic [LANES-1:0] hit;
  logic             found;
  logic [ROW_W-1:0] lead_row;

  // Lanes whose bank field selects this bank.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      hit[l] = pend_i[l] &&
               (addr_i[l*ADDR_W +: BANK_W] == BANK_W'(BANK_ID));
    end
  end

  // Lowest pending lane decides which row this cycle serves.
  always_comb begin
    found    = 1'b0;
    lead_row = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit[l] && !found) begin
        found    = 1'b1;
        lead_row = addr_i[l*ADDR_W+BANK_W +: ROW_W];
      end
    end
  end

  // Every lane on the same row rides along; the last writer in lane order
  // (the highest-numbered one) provides the stored word.
  always_comb begin
    serve_o = '0;
    wr_o    = 1'b0;
    wdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit[l] && (addr_i[l*ADDR_W+BANK_W +: ROW_W] == lead_row)) begin
        serve_o[l] = 1'b1;
        if (we_i[l]) begin
          wr_o    = 1'b1;
          wdata_o = wdata_i[l*WORD_W +: WORD_W];
        end
      end
    end
  end

  assign row_o = lead_row;

endmodule

// File: rtl/lbs_bank_mem.sv
`timescale 1ns/1ps
// One bank: single row port, combinational read of the addressed row,
// write at the clock edge (read returns the value held before that write).
module lbs_bank_mem #(
  parameter int ROWS   = 16,
  parameter int WORD_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              wr_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);

  logic [WORD_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (wr_i) begin
      cells[row_i] <= wdata_i;
    end
  end

  assign rdata_o = cells[row_i];

endmodule

// File: rtl/lane_bank_scratch.sv
`timescale 1ns/1ps
module lane_bank_scratch
  import lbs_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int WORD_W = 32,
  parameter int WORDS  = 256,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROWS   = WORDS / BANKS,
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [LANES-1:0]        lane_act,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [LANES*WORD_W-1:0] lane_wdata,
  output logic                    busy,
  output logic                    done,
  output logic [LANES*WORD_W-1:0] rdata
);

  // ---------------------------------------------------------------- state
  ctl_state_e              st_q, st_d;
  logic                    done_q, done_d;
  logic [LANES-1:0]        pend_q, pend_d;
  logic [WORD_W-1:0]       rd_q [LANES];
  logic [WORD_W-1:0]       rd_d [LANES];

  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        we_q;
  logic [LANES*WORD_W-1:0] wd_q;

  logic                    accept;
  logic                    serving;
  logic                    cap_en;
  logic                    rd_en;

  logic [LANES-1:0]        serve_b [BANKS];
  logic                    bank_wr [BANKS];
  logic [ROW_W-1:0]        bank_row [BANKS];
  logic [WORD_W-1:0]       bank_wd [BANKS];
  logic [WORD_W-1:0]       bank_rd [BANKS];
  logic [LANES-1:0]        served;

  assign serving = (st_q == ST_SERVE);
  assign accept  = req_valid && (st_q == ST_IDLE);
  assign cap_en  = accept;
  assign rd_en   = accept || serving;

  // ------------------------------------------------------ request capture
  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= lane_addr;
      we_q   <= lane_we;
      wd_q   <= lane_wdata;
    end
  end

  // ------------------------------------------------------- bank datapath
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    lbs_bank_pick #(
      .LANES   (LANES),
      .BANKS   (BANKS),
      .ADDR_W  (ADDR_W),
      .WORD_W  (WORD_W),
      .BANK_ID (b)
    ) pick_i (
      .pend_i  (pend_q),
      .addr_i  (addr_q),
      .we_i    (we_q),
      .wdata_i (wd_q),
      .serve_o (serve_b[b]),
      .wr_o    (bank_wr[b]),
      .row_o   (bank_row[b]),
      .wdata_o (bank_wd[b])
    );

    lbs_bank_mem #(
      .ROWS   (ROWS),
      .WORD_W (WORD_W)
    ) mem_i (
      .clk     (clk),
      .wr_i    (bank_wr[b] && serving),
      .row_i   (bank_row[b]),
      .wdata_i (bank_wd[b]),
      .rdata_o (bank_rd[b])
    );
  end

  // Each lane belongs to one bank, so the union gives this cycle's lanes.
  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) begin
      served = served | serve_b[b];
    end
  end

  // ------------------------------------------------------------ next state
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    pend_d = pend_q;
    for (int l = 0; l < LANES; l++) begin
      rd_d[l] = rd_q[l];
    end

    if (accept) begin
      st_d   = ST_SERVE;
      pend_d = lane_act;
      for (int l = 0; l < LANES; l++) begin
        rd_d[l] = '0;
      end
    end else if (serving) begin
      pend_d = pend_q & ~served;
      for (int l = 0; l < LANES; l++) begin
        if (served[l] && !we_q[l]) begin
          rd_d[l] = bank_rd[addr_q[l*ADDR_W +: BANK_W]];
        end
      end
      if (pend_d == '0) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  // ------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        rd_q[l] <= '0;
      end
    end else if (rd_en) begin
      for (int l = 0; l < LANES; l++) begin
        rd_q[l] <= rd_d[l];
      end
    end
  end

  // --------------------------------------------------------------- outputs
  assign busy = serving;
  assign done = done_q;

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign rdata[l*WORD_W +: WORD_W] = rd_q[l];
  end

endmodule

// File: rtl/lbs_checker.sv
`timescale 1ns/1ps
module lbs_checker #(
  parameter int LANES  = 16,
  parameter int WORD_W = 32,
  localparam int CNT_W = $clog2(LANES) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    busy,
  input logic                    done,
  input logic [LANES*WORD_W-1:0] rdata
);

  // Counts stall cycles already spent on the current request.
  logic [CNT_W-1:0] stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_cnt <= '0;
    end else if (busy) begin
      stall_cnt <= stall_cnt + 1'b1;
    end else begin
      stall_cnt <= '0;
    end
  end

  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy); // R7

  AST_DONE_FOLLOWS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R7

  AST_DONE_CLEARS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !req_valid |=> $stable(rdata)); // R7

  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stall_cnt < CNT_W'(LANES))); // R4

endmodule

bind lane_bank_scratch lbs_checker #(
  .LANES  (LANES),
  .WORD_W (WORD_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .rdata     (rdata)
);

// File: tb/lane_bank_scratch_tb_top.sv
`timescale 1ns/1ps
module lane_bank_scratch_tb_top;

  logic         clk;
  logic         rst_n;
  logic         req;
  logic [15:0]  lane_act;
  logic [15:0]  lane_we;
  logic [127:0] lane_addr;
  logic [511:0] lane_wdata;
  logic         busy;
  logic         done;
  logic [511:0] rdata;

  logic [7:0]   b_addr [16];
  logic [31:0]  b_wd   [16];
  logic [31:0]  model  [256];

  int n_chk;
  int n_fail;

  lane_bank_scratch dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req),
    .lane_act   (lane_act),
    .lane_we    (lane_we),
    .lane_addr  (lane_addr),
    .lane_wdata (lane_wdata),
    .busy       (busy),
    .done       (done),
    .rdata      (rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_comb begin
    for (int l = 0; l < 16; l++) begin
      lane_addr[l*8 +: 8]   = b_addr[l];
      lane_wdata[l*32 +: 32] = b_wd[l];
    end
  end

  function automatic logic [31:0] vpat(input int a);
    vpat = {8'h5A, 8'(a), ~8'(a), 8'h3C};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_idle();
    lane_act = '0;
    lane_we  = '0;
    for (int l = 0; l < 16; l++) begin
      b_addr[l] = '0;
      b_wd[l]   = '0;
    end
  endtask

  // Issue the request currently on the lane fields and check cycles, done, data.
  task automatic do_req(input string tag, input bit inject);
    int          per_bank [16];
    int          ek;
    int          k;
    logic [31:0] exp_rd [16];
    for (int b = 0; b < 16; b++) per_bank[b] = 0;
    for (int l = 0; l < 16; l++) begin
      if (lane_act[l]) begin
        bit dup;
        dup = 1'b0;
        for (int m = 0; m < l; m++)
          if (lane_act[m] && b_addr[m] == b_addr[l]) dup = 1'b1;
        if (!dup) per_bank[b_addr[l] % 16]++;
      end
    end
    ek = 1;
    for (int b = 0; b < 16; b++) if (per_bank[b] > ek) ek = per_bank[b];
    for (int l = 0; l < 16; l++)
      exp_rd[l] = (lane_act[l] && !lane_we[l]) ? model[b_addr[l]] : 32'h0;
    for (int l = 0; l < 16; l++)
      if (lane_act[l] && lane_we[l]) model[b_addr[l]] = b_wd[l];

    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    k = 0;
    while (busy && k < 40) begin
      k++;
      if (inject && k == 2) begin
        // R8: a second offer during the stall must be dropped
        lane_act = '1;
        lane_we  = '1;
        for (int l = 0; l < 16; l++) begin
          b_addr[l] = 8'd200;
          b_wd[l]   = 32'hDEAD0000 | l;
        end
        req = 1'b1;
      end
      @(negedge clk);
      req = 1'b0;
    end
    chk(tag, "stall cycles", k, ek);
    chk(tag, "done pulse", {31'd0, done}, 32'd1);
    for (int l = 0; l < 16; l++)
      chk(tag, $sformatf("rdata lane %0d", l), rdata[l*32 +: 32], exp_rd[l]);
  endtask

  task automatic t_reset();
    chk("R10", "busy", {31'd0, busy}, 32'd0);
    chk("R10", "done", {31'd0, done}, 32'd0);
    for (int l = 0; l < 16; l++)
      chk("R10", "rdata", rdata[l*32 +: 32], 32'd0);
  endtask

  task automatic t_fill();
    for (int r = 0; r < 16; r++) begin
      set_idle();
      lane_act = '1;
      lane_we  = '1;
      for (int l = 0; l < 16; l++) begin
        b_addr[l] = 8'(r*16 + l);
        b_wd[l]   = vpat(r*16 + l);
      end
      do_req("R2", 1'b0);
    end
  endtask

  task automatic t_offset_read();
    set_idle();
    lane_act = '1;
    for (int l = 0; l < 16; l++) b_addr[l] = 8'(5 + l);
    do_req("R1", 1'b0);
  endtask

  task automatic t_broadcast();
    set_idle();
    lane_act = '1;
    for (int l = 0; l < 16; l++) b_addr[l] = 8'd37;
    do_req("R3", 1'b0);
  endtask

  task automatic t_stride(input int s);
    set_idle();
    lane_act = '1;
    for (int l = 0; l < 16; l++) b_addr[l] = 8'((s * l + 1) % 256);
    do_req($sformatf("R4 stride %0d", s), 1'b0);
  endtask

  task automatic t_mixed();
    // two rows of bank 0, each broadcast to 8 lanes: 2 cycles (R3, R4)
    set_idle();
    lane_act = '1;
    for (int l = 0; l < 16; l++) b_addr[l] = (l < 8) ? 8'd0 : 8'd16;
    do_req("R3/R4 mixed", 1'b0);
  endtask

  task automatic t_same_write();
    set_idle();
    lane_act = 16'h03FF;
    lane_we  = '1;
    for (int l = 0; l < 16; l++) begin
      b_addr[l] = 8'd50;
      b_wd[l]   = (l < 10) ? (32'h1000 + l) : 32'h0BAD0BAD;
    end
    do_req("R5 R9", 1'b0);
    set_idle();
    lane_act = '1;
    for (int l = 0; l < 16; l++) b_addr[l] = 8'd50;
    do_req("R5 readback", 1'b0);
    chk("R5", "winner", rdata[31:0], 32'h1009);
  endtask

  task automatic t_rw_same();
    set_idle();
    lane_act  = 16'h0007;
    lane_we   = 16'hFFF2;
    b_addr[0] = 8'd60;
    b_addr[1] = 8'd60;
    b_wd[1]   = 32'hCAFE0001;
    b_addr[2] = 8'd61;
    for (int l = 3; l < 16; l++) begin
      b_addr[l] = 8'd70;
      b_wd[l]   = 32'hBADBAD00;
    end
    do_req("R6 R9", 1'b0);
    chk("R6", "old value to reader", rdata[31:0], vpat(60));
    set_idle();
    lane_act = '1;
    for (int l = 0; l < 16; l++) b_addr[l] = (l < 8) ? 8'd60 : 8'd70;
    do_req("R6/R9 readback", 1'b0);
  endtask

  task automatic t_busy_ignore();
    set_idle();
    lane_act = '1;
    for (int l = 0; l < 16; l++) b_addr[l] = 8'(16 * l + 8);
    do_req("R8 R4", 1'b1);
    @(negedge clk);
    chk("R7", "done low after pulse", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R7", "rdata held", rdata[3*32 +: 32], vpat(56));
    set_idle();
    lane_act = '1;
    for (int l = 0; l < 16; l++) b_addr[l] = 8'd200;
    do_req("R8 readback", 1'b0);
  endtask

  task automatic t_empty();
    set_idle();
    lane_we = '1;
    for (int l = 0; l < 16; l++) b_wd[l] = 32'hFFFFFFFF;
    do_req("R9 empty", 1'b0);
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    req    = 1'b0;
    set_idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fill();
    t_offset_read();
    t_broadcast();
    t_stride(1);
    t_stride(2);
    t_stride(3);
    t_stride(8);
    t_stride(16);
    t_mixed();
    t_same_write();
    t_rw_same();
    t_busy_ignore();
    t_empty();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule